// File: doc/BRIEF.md
# Bus Signal-Free-Time Timer

This block measures the quiet interval that a single-wire consumer-electronics control bus needs before a node may drive a new message. The timer counts in half nominal data bit periods. Each half-bit is one cycle of the `tick` clock-enable input, so the count does not depend on the system clock frequency. When the selected interval has passed with the line idle, it raises `bus_free`. A transmitter uses that signal to start sending. It asserts `tx_start` once the first bit actually goes out.

A 3-bit setting selects the interval. A nonzero code n selects 2n−1 half-bits, which is 0.5 + (n−1) bit periods. Code 0 selects a default that depends on context:
- 2.5 bit periods after this node's own successful transmission.
- 4 bit periods for a new initiator.
- 6 bit periods for a retry after a failed attempt.

A start-option bit chooses what starts a count. When it is clear, the software start-of-message request starts the count. When it is set, the end of any transmitted or received message starts it.

The block takes the setting and the context inputs at the moment a count starts. While the count runs, any low level on the bus line clears it back to zero.

Top module: `sft_timer`

## Requirements
- R1: After reset, `bus_free` is 0, and no count is running until a start event arrives.
- R2: With a nonzero code n on `sft_code`, `bus_free` rises on the clock edge that samples the (2n−1)-th `tick` after the start event. It is still 0 after 2n−2 ticks.
- R3: With `sft_code` = 0, the interval is 12 half-bits if `ctx_retry` = 1, else 5 if `ctx_own_ok` = 1, else 8. `ctx_retry` takes priority over `ctx_own_ok`.
- R4: With `start_opt` = 0, only a `som_req` pulse starts a count. Pulses on `tx_end` and `rx_end` are ignored, and `bus_free` stays 0 however many ticks follow.
- R5: With `start_opt` = 1, a pulse on either `tx_end` or `rx_end` starts a count. `som_req` is ignored.
- R6: While a count runs, a low `bus_line` clears the count to zero, and ticks seen while the line is low are not counted. After the line goes high again, the full interval must elapse.
- R7: Once raised, `bus_free` stays 1 until `tx_start` is seen, a new start event arrives, or `enable` drops. It reads 0 on the cycle after `tx_start`.
- R8: While `enable` = 0, `bus_free` is 0, any running count is abandoned, and start events are ignored.
- R9: `tick` pulses that arrive while no count is running have no effect.
- R10: The setting and the context inputs are captured when the count starts. Changing them during the count does not change the interval.
- R11: A new start event during a running count restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low clears and holds idle |
| tick | input | 1 | One-cycle pulse per half nominal bit period |
| bus_line | input | 1 | Sensed bus level, 1 = idle high |
| sft_code | input | 3 | Signal-free-time setting, 0 = context default |
| start_opt | input | 1 | 0: start on `som_req`; 1: start on message end |
| som_req | input | 1 | Start-of-message request pulse |
| tx_end | input | 1 | End-of-transmission pulse |
| rx_end | input | 1 | End-of-reception pulse |
| ctx_own_ok | input | 1 | Previous message was this node's successful transmission |
| ctx_retry | input | 1 | Next transmission is a retry after failure |
| tx_start | input | 1 | Transmission has started; drops `bus_free` |
| bus_free | output | 1 | Interval elapsed, node may transmit |

## Verification
The bench checks the off-by-one boundary for every interval. A design that counts one half-bit too many or too few shows `bus_free` high one tick early, or still low at the exact tick. It drives start events of the wrong kind for the selected start option; a design with the arm selection swapped would raise `bus_free` there. It pulls the line low partway through a count and changes the setting during a count. A design that only paused the count on a low line would finish early. A design that read the setting live would finish at the new interval. It also covers re-arming, disabling mid-count and the hold of `bus_free`. Errors there show up as a stale completion or as `bus_free` dropping on its own.

// File: rtl/sft_pkg.sv
package sft_pkg;
  // Context that selects the default interval when the setting is zero.
  typedef enum logic [1:0] {
    CTX_NEW   = 2'd0,
    CTX_OWN   = 2'd1,
    CTX_RETRY = 2'd2
  } dflt_ctx_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sft_arm_sel.sv
// Picks which event starts a free-time count, according to the start option.
module sft_arm_sel (
  input  logic enable,
  input  logic start_opt,
  input  logic som_req,
  input  logic tx_end,
  input  logic rx_end,
  output logic arm
);
  logic msg_end;

  assign msg_end = tx_end | rx_end;

  always_comb begin
    if (!enable)        arm = 1'b0;
    else if (start_opt) arm = msg_end;
    else                arm = som_req;
  end
endmodule

// File: rtl/sft_target.sv
// Maps the setting code (plus the default context) to a length in half-bits.
module sft_target
  import sft_pkg::*;
#(
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned DEF_OWN   = 5,
  parameter int unsigned DEF_NEW   = 8,
  parameter int unsigned DEF_RETRY = 12
) (
  input  logic [CODE_W-1:0] code,
  input  logic              ctx_own_ok,
  input  logic              ctx_retry,
  output logic [CNT_W-1:0]  target
);
  localparam int unsigned NCODES = 1 << CODE_W;

  dflt_ctx_e        ctx;
  logic [CNT_W-1:0] dflt_len;
  logic [CNT_W-1:0] len_lut [NCODES];

  always_comb begin
    if (ctx_retry)       ctx = CTX_RETRY;
    else if (ctx_own_ok) ctx = CTX_OWN;
    else                 ctx = CTX_NEW;
  end

  always_comb begin
    unique case (ctx)
      CTX_RETRY: dflt_len = CNT_W'(DEF_RETRY);
      CTX_OWN:   dflt_len = CNT_W'(DEF_OWN);
      default:   dflt_len = CNT_W'(DEF_NEW);
    endcase
  end

  assign len_lut[0] = dflt_len;

  // Code n selects half a bit plus (n-1) whole bits: 2n-1 half-bits.
  for (genvar gi = 1; gi < NCODES; gi++) begin : g_lut
    assign len_lut[gi] = CNT_W'(2 * gi - 1);
  end

  assign target = len_lut[code];
endmodule

// File: rtl/sft_count.sv
// Half-bit counter: cleared when the line is low, raises the free flag at the target.
module sft_count #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             arm,
  input  logic             tick,
  input  logic             bus_line,
  input  logic             tx_start,
  input  logic [CNT_W-1:0] target,
  output logic             bus_free
);
  logic             run_q;
  logic             free_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             reach;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign reach   = cnt_inc >= {1'b0, tgt_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      free_q <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= '0;
    end else if (!enable || tx_start) begin
      run_q  <= 1'b0;
      free_q <= 1'b0;
      cnt_q  <= '0;
    end else if (arm) begin
      run_q  <= 1'b1;
      free_q <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= target;
    end else if (run_q) begin
      if (!bus_line) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (reach) begin
          run_q  <= 1'b0;
          free_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_inc[CNT_W-1:0];
        end
      end
    end
  end

  assign bus_free = free_q;
endmodule

// File: rtl/sft_timer.sv
module sft_timer
  import sft_pkg::*;
#(
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned DEF_OWN   = 5,
  parameter int unsigned DEF_NEW   = 8,
  parameter int unsigned DEF_RETRY = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              bus_line,
  input  logic [CODE_W-1:0] sft_code,
  input  logic              start_opt,
  input  logic              som_req,
  input  logic              tx_end,
  input  logic              rx_end,
  input  logic              ctx_own_ok,
  input  logic              ctx_retry,
  input  logic              tx_start,
  output logic              bus_free
);
  localparam int unsigned MAX_CODE = 2 * ((1 << CODE_W) - 1) - 1;
  localparam int unsigned MAX_HALF = max_u(max_u(MAX_CODE, DEF_OWN), max_u(DEF_NEW, DEF_RETRY));
  localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1);

  logic             arm;
  logic [CNT_W-1:0] target;

  sft_arm_sel u_arm (
    .enable    (enable),
    .start_opt (start_opt),
    .som_req   (som_req),
    .tx_end    (tx_end),
    .rx_end    (rx_end),
    .arm       (arm)
  );

  sft_target #(
    .CODE_W    (CODE_W),
    .CNT_W     (CNT_W),
    .DEF_OWN   (DEF_OWN),
    .DEF_NEW   (DEF_NEW),
    .DEF_RETRY (DEF_RETRY)
  ) u_tgt (
    .code       (sft_code),
    .ctx_own_ok (ctx_own_ok),
    .ctx_retry  (ctx_retry),
    .target     (target)
  );

  sft_count #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .arm      (arm),
    .tick     (tick),
    .bus_line (bus_line),
    .tx_start (tx_start),
    .target   (target),
    .bus_free (bus_free)
  );
endmodule

// File: rtl/sft_timer_chk.sv
module sft_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tick,
  input logic bus_line,
  input logic start_opt,
  input logic som_req,
  input logic tx_end,
  input logic rx_end,
  input logic tx_start,
  input logic bus_free
);
  logic start_seen;
  assign start_seen = start_opt ? (tx_end | rx_end) : som_req;

  // R2, R9: the flag only rises on a sampled tick
  p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> $past(tick));

  // R6: the flag never rises from a cycle with the line low
  p_rise_line_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> $past(bus_line));

  // R7: transmission start drops the flag
  p_tx_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !bus_free);

  // R7: the flag holds with no clearing cause
  p_free_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_free && enable && !tx_start && !start_seen) |=> bus_free);

  // R8: disabled means not free
  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !bus_free);
endmodule

bind sft_timer sft_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .tick      (tick),
  .bus_line  (bus_line),
  .start_opt (start_opt),
  .som_req   (som_req),
  .tx_end    (tx_end),
  .rx_end    (rx_end),
  .tx_start  (tx_start),
  .bus_free  (bus_free)
);

// File: tb/sim_sft_timer.sv
`timescale 1ns/1ps
module sim_sft_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       tick = 1'b0;
  logic       bus_line = 1'b1;
  logic [2:0] sft_code = 3'd0;
  logic       start_opt = 1'b0;
  logic       som_req = 1'b0;
  logic       tx_end = 1'b0;
  logic       rx_end = 1'b0;
  logic       ctx_own_ok = 1'b0;
  logic       ctx_retry = 1'b0;
  logic       tx_start = 1'b0;
  logic       bus_free;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sft_timer u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .bus_line(bus_line),
    .sft_code(sft_code), .start_opt(start_opt), .som_req(som_req), .tx_end(tx_end),
    .rx_end(rx_end), .ctx_own_ok(ctx_own_ok), .ctx_retry(ctx_retry),
    .tx_start(tx_start), .bus_free(bus_free)
  );

  // Vector: code[11:9] retry[8] own[7] opt[6] src[5:4] (0 som,1 tx_end,2 rx_end) len[3:0]
  localparam int NVEC = 10;
  localparam logic [11:0] VEC [NVEC] = '{
    {3'd1, 1'b0, 1'b0, 1'b0, 2'd0, 4'd1},
    {3'd2, 1'b0, 1'b0, 1'b0, 2'd0, 4'd3},
    {3'd4, 1'b0, 1'b0, 1'b0, 2'd0, 4'd7},
    {3'd7, 1'b0, 1'b0, 1'b0, 2'd0, 4'd13},
    {3'd3, 1'b0, 1'b0, 1'b1, 2'd1, 4'd5},
    {3'd5, 1'b0, 1'b0, 1'b1, 2'd2, 4'd9},
    {3'd0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd5},
    {3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd8},
    {3'd0, 1'b1, 1'b0, 1'b1, 2'd1, 4'd12},
    {3'd0, 1'b1, 1'b1, 1'b1, 2'd2, 4'd12}
  };

  task automatic chk(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: bus_free=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic pulse_src(input int src);
    @(negedge clk);
    case (src)
      0: som_req = 1'b1;
      1: tx_end  = 1'b1;
      default: rx_end = 1'b1;
    endcase
    @(negedge clk);
    som_req = 1'b0; tx_end = 1'b0; rx_end = 1'b0;
  endtask

  task automatic pulse_tx_start();
    @(negedge clk) tx_start = 1'b1;
    @(negedge clk) tx_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_free, 1'b0, "R1 in reset");
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);
    chk(bus_free, 1'b0, "R1 after reset");
    ticks(20);
    chk(bus_free, 1'b0, "R9 ticks with no count");

    // Table walk: R2/R3/R4/R5 boundary, then R7 clear
    for (int v = 0; v < NVEC; v++) begin
      sft_code   = VEC[v][11:9];
      ctx_retry  = VEC[v][8];
      ctx_own_ok = VEC[v][7];
      start_opt  = VEC[v][6];
      pulse_src(int'(VEC[v][5:4]));
      ticks(int'(VEC[v][3:0]) - 1);
      chk(bus_free, 1'b0, $sformatf("R2/R3 vec%0d one tick short", v));
      ticks(1);
      chk(bus_free, 1'b1, $sformatf("R2/R3 vec%0d at length", v));
      pulse_tx_start();
      chk(bus_free, 1'b0, $sformatf("R7 vec%0d tx_start clears", v));
    end
    ctx_retry = 1'b0; ctx_own_ok = 1'b0;

    // R4: message ends ignored with start_opt=0
    start_opt = 1'b0; sft_code = 3'd1;
    pulse_src(1); pulse_src(2); ticks(20);
    chk(bus_free, 1'b0, "R4 ends ignored");

    // R5: som_req ignored with start_opt=1
    start_opt = 1'b1;
    pulse_src(0); ticks(20);
    chk(bus_free, 1'b0, "R5 som ignored");
    start_opt = 1'b0;

    // R6: line low mid-count clears the count
    sft_code = 3'd3;
    pulse_src(0); ticks(3);
    @(negedge clk) bus_line = 1'b0;
    ticks(3);
    @(negedge clk) bus_line = 1'b1;
    ticks(4);
    chk(bus_free, 1'b0, "R6 restart not yet done");
    ticks(1);
    chk(bus_free, 1'b1, "R6 full interval after line high");

    // R7: hold
    ticks(10);
    repeat (5) @(negedge clk);
    chk(bus_free, 1'b1, "R7 holds");
    pulse_tx_start();
    chk(bus_free, 1'b0, "R7 cleared");

    // R10: setting captured at start
    sft_code = 3'd2;
    pulse_src(0);
    sft_code = 3'd7;
    ticks(2);
    chk(bus_free, 1'b0, "R10 short of captured");
    ticks(1);
    chk(bus_free, 1'b1, "R10 captured length");
    pulse_tx_start();

    // R11: restart during count
    sft_code = 3'd3;
    pulse_src(0); ticks(4);
    pulse_src(0); ticks(4);
    chk(bus_free, 1'b0, "R11 restarted count");
    ticks(1);
    chk(bus_free, 1'b1, "R11 completes after restart");

    // R8: disable clears, aborts and blocks start events
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk(bus_free, 1'b0, "R8 disable clears flag");
    pulse_src(0); ticks(3);
    @(negedge clk) enable = 1'b1;
    ticks(10);
    chk(bus_free, 1'b0, "R8 start ignored while disabled");
    pulse_src(0); ticks(2);
    @(negedge clk) enable = 1'b0;
    @(negedge clk) enable = 1'b1;
    ticks(20);
    chk(bus_free, 1'b0, "R8 count abandoned");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule